// File: doc/BRIEF.md
# Predictive Switching-State Search for a Four-Level Three-Phase Converter

Once per control period this block picks one switching state for each of the three legs of a four-level converter. Every leg holds two flying capacitors. Each leg can take one of six legal gate patterns, which gives 216 joint candidates. The block walks through all of them, one per clock. It scores each candidate with two terms added together. The first is the squared error between a required phase-voltage vector, computed upstream, and the phase voltages the candidate would produce. The second is a weighted term that penalises how far the predicted flying-capacitor voltages move from one third of the DC link. The candidate with the lowest score drives the gates in the next period.

A controller loads a snapshot of the measurements and the constants and then pulses `start_i`. About 216 clocks later `done_o` pulses and the new gate words appear on `gate_o`. The controller supplies two constants: the sampling-step to capacitance ratio and the balancing weight. Both are fixed-point values, so the block needs no divider.

Top module: `mlc_state_search`

## Requirements
- R1: While reset is high and after it falls, and before any scan completes, every phase drives gate word 6'b000111 (level 0), and `done_o` is low.
- R2: A `start_i` sampled high while idle begins a scan. `done_o` is high for exactly one cycle, 216 clock edges after the edge that accepted the start, and the new gate words appear together with it.
- R3: Each leg state has a code, a gate word (bit 5 is switch 1 and bit 0 is switch 6) and an output level with respect to the negative rail. The levels use Vdc and the measured capacitor voltages c1 and c2. Code 0 has word 000111 and gives 0. Code 1 has word 001101 and gives c2. Code 2 has word 100110 and gives Vdc−c1−c2. Code 3 has word 011001 and gives c1+c2. Code 4 has word 101100 and gives Vdc−c1. Code 5 has word 110000 and gives Vdc.
- R4: A phase voltage is its leg level minus the mean of the three leg levels. The tracking term is Σp (3·vref_p − 3·leg_p + Σleg)², which is nine times the squared phase-voltage error.
- R5: The predicted capacitor voltages are c1 + (s1−s2)·k and c2 + (s5−s6)·k. Here sN is switch N of the candidate's gate word, k = (ktsc_i·iph) >>> KF, and the product is signed, so the sign of the current sets the direction.
- R6: The balancing term is (weight_i · Σ d²) >> WF. The sum runs over both predicted capacitors of all three phases, and d is each prediction minus vthird_i. A weight of zero removes this term.
- R7: Candidates are scanned with the phase-a code as the most significant digit and the phase-c code as the least significant. Among candidates with equal total cost, the one scanned first wins.
- R8: Every squared term, every partial sum and the total cost are clipped at 2^CW−1 instead of wrapping.
- R9: The gate words change only at the end of a scan. A `start_i` sampled during a scan, including on its final edge, is ignored. Input changes after the accepting edge do not affect the result.
- R10: Each phase of `gate_o` always carries one of the six gate words listed in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Requests a scan; accepted only while idle |
| vdc_i | input | DW | DC-link voltage, signed |
| vthird_i | input | DW | Capacitor target (one third of the link), signed |
| ktsc_i | input | DW | Sampling step over capacitance, signed, KF fraction bits |
| weight_i | input | DW | Balancing weight, unsigned, WF fraction bits |
| vref_i | input | 3×DW | Required phase voltage per phase, signed |
| vc1_i | input | 3×DW | Upper flying-capacitor voltage per phase, signed |
| vc2_i | input | 3×DW | Lower flying-capacitor voltage per phase, signed |
| iph_i | input | 3×DW | Phase current, signed |
| gate_o | output | 3×6 | Gate word per phase, element 0 is phase a |
| done_o | output | 1 | One-cycle pulse when a scan has finished |

## Verification
Two things happen on the final edge of a scan. The last candidate is compared against the best cost so far, and the result is committed to `gate_o` and `done_o`. On that same edge the controller may also raise a new start. The bench drives a start pulse on the final edge and another in the middle of the scan, and it changes the inputs at the mid-scan pulse. The run passes if the gate words come from the first snapshot, if they hold their old value up to the final edge, and if no second `done_o` follows in the next 300 cycles. Tie vectors and a vector where every candidate saturates show whether the comparison on the final edge still prefers the earlier candidate.

// File: rtl/mss_pkg.sv
`timescale 1ns/1ps
package mss_pkg;
  localparam int unsigned NPH = 3;  // phases
  localparam int unsigned NST = 6;  // legal states per leg

  // Leg-state codes, in scan order
  localparam logic [2:0] C_A  = 3'd0;
  localparam logic [2:0] C_B1 = 3'd1;
  localparam logic [2:0] C_B2 = 3'd2;
  localparam logic [2:0] C_C1 = 3'd3;
  localparam logic [2:0] C_C2 = 3'd4;
  localparam logic [2:0] C_D  = 3'd5;

  // Gate word, bit 5 = switch 1 ... bit 0 = switch 6
  function automatic logic [5:0] gate_of(input logic [2:0] c);
    case (c)
      C_B1:    return 6'b001101;
      C_B2:    return 6'b100110;
      C_C1:    return 6'b011001;
      C_C2:    return 6'b101100;
      C_D:     return 6'b110000;
      default: return 6'b000111;
    endcase
  endfunction

  function automatic logic gate_ok(input logic [5:0] g);
    return g inside {6'b000111, 6'b001101, 6'b100110,
                     6'b011001, 6'b101100, 6'b110000};
  endfunction
endpackage

// File: rtl/mss_scan_ctl.sv
`timescale 1ns/1ps
module mss_scan_ctl #(
  parameter int unsigned NPH = 3,
  parameter int unsigned NST = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 accept_o,
  output logic                 first_o,
  output logic                 last_o,
  output logic [NPH-1:0][2:0]  code_o
);
  logic [NPH:0]          carry;
  logic [NPH-1:0][2:0]   code_nx;

  assign carry[0] = 1'b1;
  // digit NPH-1 (phase c) counts fastest
  for (genvar j = 0; j < NPH; j++) begin : g_dig
    localparam int unsigned D = NPH - 1 - j;
    logic wrap;
    assign wrap       = (code_o[D] == 3'(NST - 1));
    assign code_nx[D] = carry[j] ? (wrap ? 3'd0 : code_o[D] + 3'd1) : code_o[D];
    assign carry[j+1] = carry[j] & wrap;
  end

  assign accept_o = start_i & ~busy_o;
  assign first_o  = busy_o & (code_o == '0);
  assign last_o   = busy_o & carry[NPH];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      code_o <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      code_o <= '0;
    end else if (busy_o) begin
      if (last_o) busy_o <= 1'b0;
      code_o <= code_nx;
    end
  end
endmodule

// File: rtl/mss_phase_eval.sv
`timescale 1ns/1ps
module mss_phase_eval
  import mss_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 32
) (
  input  logic [2:0]           code_i,
  input  logic signed [DW-1:0] vdc_i,
  input  logic signed [DW-1:0] vc1_i,
  input  logic signed [DW-1:0] vc2_i,
  input  logic signed [DW-1:0] vth_i,
  input  logic signed [2*DW-1:0] ki_i,
  output logic signed [DW+1:0] leg_o,
  output logic [CW-1:0]        dev_sq_o
);
  localparam int unsigned LW = DW + 2;
  localparam int unsigned PW = 2*DW + 2;
  localparam int unsigned QW = 2*PW;
  localparam logic signed [LW-1:0] LZ = '0;
  localparam logic signed [PW-1:0] PZ = '0;

  logic [5:0] g;
  logic s1, s2, s3, s5, s6, unused_s4;
  assign g = gate_of(code_i);
  assign {s1, s2, s3, unused_s4, s5, s6} = g;

  // level with respect to the negative rail
  always_comb begin
    if (s1)
      leg_o = LW'(vdc_i) - (s2 ? LZ : LW'(vc1_i)) - ((s2 | s3) ? LZ : LW'(vc2_i));
    else
      leg_o = (s2 ? LW'(vc1_i) : LZ) + (s3 ? LW'(vc2_i) : LZ);
  end

  logic signed [PW-1:0] adj1, adj2, d1, d2;
  logic signed [QW-1:0] w1, w2;
  logic [QW-1:0]        q1, q2;
  logic [CW-1:0]        q1s, q2s;
  logic [CW:0]          qsum;

  assign adj1 = (s1 & ~s2) ? PW'(ki_i) : (~s1 & s2) ? -PW'(ki_i) : PZ;
  assign adj2 = (s5 & ~s6) ? PW'(ki_i) : (~s5 & s6) ? -PW'(ki_i) : PZ;
  assign d1   = PW'(vc1_i) + adj1 - PW'(vth_i);
  assign d2   = PW'(vc2_i) + adj2 - PW'(vth_i);
  assign w1   = QW'(d1);
  assign w2   = QW'(d2);
  assign q1   = w1 * w1;
  assign q2   = w2 * w2;
  assign q1s  = (|q1[QW-1:CW]) ? '1 : q1[CW-1:0];
  assign q2s  = (|q2[QW-1:CW]) ? '1 : q2[CW-1:0];
  assign qsum = {1'b0, q1s} + {1'b0, q2s};
  assign dev_sq_o = qsum[CW] ? '1 : qsum[CW-1:0];
endmodule

// File: rtl/mss_cost_sum.sv
`timescale 1ns/1ps
module mss_cost_sum #(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 32,
  parameter int unsigned WF  = 8,
  parameter int unsigned NPH = 3
) (
  input  logic signed [DW+1:0] leg_i    [NPH],
  input  logic signed [DW-1:0] vref_i   [NPH],
  input  logic [CW-1:0]        dev_sq_i [NPH],
  input  logic [DW-1:0]        weight_i,
  output logic [CW-1:0]        cost_o
);
  localparam int unsigned EW = DW + 6;
  localparam int unsigned QW = 2*EW;
  localparam int unsigned MW = CW + DW;

  logic signed [EW-1:0] lsum;
  logic [CW-1:0]        tsq [NPH];
  logic [CW-1:0]        trk_acc [NPH+1];
  logic [CW-1:0]        bal_acc [NPH+1];

  always_comb begin
    lsum = '0;
    for (int p = 0; p < NPH; p++) lsum = lsum + EW'(leg_i[p]);
  end

  for (genvar p = 0; p < NPH; p++) begin : g_trk
    logic signed [EW-1:0] r, l, e;
    logic signed [QW-1:0] ew;
    logic [QW-1:0]        sq;
    logic [CW:0]          ts, bs;
    assign r  = EW'(vref_i[p]);
    assign l  = EW'(leg_i[p]);
    assign e  = (r <<< 1) + r - (l <<< 1) - l + lsum;
    assign ew = QW'(e);
    assign sq = ew * ew;
    assign tsq[p] = (|sq[QW-1:CW]) ? '1 : sq[CW-1:0];
    assign ts = {1'b0, trk_acc[p]} + {1'b0, tsq[p]};
    assign bs = {1'b0, bal_acc[p]} + {1'b0, dev_sq_i[p]};
    assign trk_acc[p+1] = ts[CW] ? '1 : ts[CW-1:0];
    assign bal_acc[p+1] = bs[CW] ? '1 : bs[CW-1:0];
  end
  assign trk_acc[0] = '0;
  assign bal_acc[0] = '0;

  logic [MW-1:0] wprod, wshift;
  logic [CW-1:0] bterm;
  logic [CW:0]   tot;
  assign wprod  = MW'(weight_i) * MW'(bal_acc[NPH]);
  assign wshift = wprod >> WF;
  assign bterm  = (|wshift[MW-1:CW]) ? '1 : wshift[CW-1:0];
  assign tot    = {1'b0, trk_acc[NPH]} + {1'b0, bterm};
  assign cost_o = tot[CW] ? '1 : tot[CW-1:0];
endmodule

// File: rtl/mlc_state_search.sv
`timescale 1ns/1ps
module mlc_state_search
  import mss_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned KF = 12,
  parameter int unsigned WF = 8,
  parameter int unsigned CW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic signed [DW-1:0]  vdc_i,
  input  logic signed [DW-1:0]  vthird_i,
  input  logic signed [DW-1:0]  ktsc_i,
  input  logic [DW-1:0]         weight_i,
  input  logic [NPH-1:0][DW-1:0] vref_i,
  input  logic [NPH-1:0][DW-1:0] vc1_i,
  input  logic [NPH-1:0][DW-1:0] vc2_i,
  input  logic [NPH-1:0][DW-1:0] iph_i,
  output logic [NPH-1:0][5:0]   gate_o,
  output logic                  done_o
);
  localparam int unsigned KW = 2*DW;

  logic                busy, accept, first, last;
  logic [NPH-1:0][2:0] code;

  mss_scan_ctl #(.NPH(NPH), .NST(NST)) u_ctl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy), .accept_o(accept), .first_o(first), .last_o(last),
    .code_o(code)
  );

  // snapshot taken on the accepting edge
  logic signed [DW-1:0] vdc_q, vth_q;
  logic [DW-1:0]        w_q;
  logic signed [DW-1:0] vref_q [NPH];
  logic signed [DW-1:0] vc1_q  [NPH];
  logic signed [DW-1:0] vc2_q  [NPH];
  logic signed [KW-1:0] ki_d   [NPH];
  logic signed [KW-1:0] ki_q   [NPH];
  logic signed [DW+1:0] leg    [NPH];
  logic [CW-1:0]        dsq    [NPH];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic signed [KW-1:0] prod;
    assign prod    = KW'($signed(ktsc_i)) * KW'($signed(iph_i[p]));
    assign ki_d[p] = prod >>> KF;

    mss_phase_eval #(.DW(DW), .CW(CW)) u_eval (
      .code_i(code[p]), .vdc_i(vdc_q), .vc1_i(vc1_q[p]), .vc2_i(vc2_q[p]),
      .vth_i(vth_q), .ki_i(ki_q[p]), .leg_o(leg[p]), .dev_sq_o(dsq[p])
    );
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vdc_q <= vdc_i;
      vth_q <= vthird_i;
      w_q   <= weight_i;
      for (int p = 0; p < NPH; p++) begin
        vref_q[p] <= $signed(vref_i[p]);
        vc1_q[p]  <= $signed(vc1_i[p]);
        vc2_q[p]  <= $signed(vc2_i[p]);
        ki_q[p]   <= ki_d[p];
      end
    end
  end

  logic [CW-1:0] cost;
  mss_cost_sum #(.DW(DW), .CW(CW), .WF(WF), .NPH(NPH)) u_cost (
    .leg_i(leg), .vref_i(vref_q), .dev_sq_i(dsq), .weight_i(w_q), .cost_o(cost)
  );

  logic [CW-1:0]       best_cost;
  logic [NPH-1:0][2:0] best_code, win_code;
  logic                take;
  assign take     = first | (cost < best_cost);
  assign win_code = take ? code : best_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      best_cost <= '1;
      best_code <= '0;
      for (int p = 0; p < NPH; p++) gate_o[p] <= gate_of(C_A);
    end else begin
      done_o <= 1'b0;
      if (busy) begin
        if (take) begin
          best_cost <= cost;
          best_code <= code;
        end
        if (last) begin
          done_o <= 1'b1;
          for (int p = 0; p < NPH; p++) gate_o[p] <= gate_of(win_code[p]);
        end
      end
    end
  end
endmodule

// File: rtl/mss_chk.sv
`timescale 1ns/1ps
module mss_chk
  import mss_pkg::*;
#(
  parameter int unsigned NP = 3,
  parameter int unsigned NS = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_i,
  input logic               done_i,
  input logic [NP-1:0][5:0] gate_i
);
  localparam int unsigned NCAND = NS**NP;
  localparam int unsigned CNTW  = $clog2(NCAND + 2);

  logic [CNTW-1:0] scan_cnt;
  always_ff @(posedge clk) begin
    if (rst)                     scan_cnt <= '0;
    else if (start_i && !busy_i) scan_cnt <= '0;
    else if (busy_i)             scan_cnt <= scan_cnt + 1'b1;
  end

  // R2
  scan_len_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |-> scan_cnt == CNTW'(NCAND));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !done_i);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (busy_i || done_i));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_i |-> $stable(gate_i));

  for (genvar p = 0; p < NP; p++) begin : g_leg
    // R10
    gate_legal_chk: assert property (@(posedge clk) disable iff (rst)
      gate_ok(gate_i[p]));
  end
endmodule

bind mlc_state_search mss_chk #(.NP(mss_pkg::NPH), .NS(mss_pkg::NST)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_i(busy),
  .done_i(done_o), .gate_i(gate_o)
);

// File: tb/mlc_state_search_bench.sv
`timescale 1ns/1ps
module mlc_state_search_bench;
  localparam int DW = 16;
  localparam int NV = 7;
  localparam int NF = 13;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic signed [DW-1:0] vdc, vth, ktsc;
  logic [DW-1:0]        w;
  logic [2:0][DW-1:0]   vref, vc1, vc2, iph;
  logic [2:0][5:0]      gate;
  logic                 done;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mlc_state_search u_mlc_state_search (
    .clk(clk), .rst(rst), .start_i(start), .vdc_i(vdc), .vthird_i(vth),
    .ktsc_i(ktsc), .weight_i(w), .vref_i(vref), .vc1_i(vc1), .vc2_i(vc2),
    .iph_i(iph), .gate_o(gate), .done_o(done)
  );

  // vdc, vthird, k(Q12), weight(Q8), vref a/b/c, c1, c2, current, expected codes a/b/c
  localparam int VT [NV][NF] = '{
    '{300, 100, 0,    256, 200,   -100,  -100,  100, 100, 0,   5, 0, 0}, // R3 top/bottom levels
    '{300, 100, 0,    256, 100,   0,     -100,  100, 100, 0,   3, 1, 0}, // R7 ties resolved by order
    '{300, 100, 0,    256, -100,  200,   -100,  100, 100, 0,   0, 5, 0}, // R4 phase voltage
    '{300, 100, 4096, 256, 0,     0,     0,     120, 100, -20, 4, 4, 4}, // R5 negative current
    '{300, 100, 4096, 0,   0,     0,     0,     120, 100, -20, 0, 0, 0}, // R6 zero weight
    '{300, 100, 4096, 256, 0,     0,     0,     80,  100, 20,  4, 4, 4}, // R5 positive current
    '{300, 100, 0,    256, 30000, 30000, 30000, 100, 100, 0,   0, 0, 0}  // R8 saturation
  };

  function automatic string row_req(int v);
    case (v)
      0: return "R3"; 1: return "R7"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R5"; default: return "R8";
    endcase
  endfunction

  // R10 gate words per code
  function automatic logic [5:0] pat(int c);
    case (c)
      1: return 6'b001101; 2: return 6'b100110; 3: return 6'b011001;
      4: return 6'b101100; 5: return 6'b110000; default: return 6'b000111;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int v);
    vdc = DW'(VT[v][0]); vth = DW'(VT[v][1]); ktsc = DW'(VT[v][2]); w = DW'(VT[v][3]);
    for (int p = 0; p < 3; p++) begin
      vref[p] = DW'(VT[v][4+p]);
      vc1[p]  = DW'(VT[v][7]);
      vc2[p]  = DW'(VT[v][8]);
      iph[p]  = DW'(VT[v][9]);
    end
  endtask

  task automatic gates_are(input string req, input int e0, input int e1, input int e2);
    int ex [3];
    ex = '{e0, e1, e2};
    for (int p = 0; p < 3; p++)
      chk(gate[p] == pat(ex[p]), req, $sformatf("gate phase %0d", p), gate[p], pat(ex[p]));
  endtask

  task automatic scan(output int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      @(posedge clk); n++; #1;
    end
    if (n >= 1000) chk(1'b0, "R2", "scan watchdog", n, 216);
  endtask

  initial begin
    #500000;
    chk(1'b0, "R2", "global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, pulses;
    load(0);
    repeat (4) @(negedge clk);
    #1;
    // R1 state held during reset
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    gates_are("R1", 0, 0, 0);

    for (int v = 0; v < NV; v++) begin
      load(v);
      scan(n);
      chk(n == 216, "R2", $sformatf("latency vector %0d", v), n, 216);
      gates_are(row_req(v), VT[v][10], VT[v][11], VT[v][12]);
      @(posedge clk); #1;
      chk(done == 1'b0, "R2", "done width", done, 0);
    end

    // R9: mid-scan hold, ignored starts (mid-scan and final edge), snapshot
    load(0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      @(posedge clk); n++; #1;
      if (n == 99) load(2);
      start = (n == 99 || n == 215);
      if (n == 150) gates_are("R9", 0, 0, 0);
    end
    start = 1'b0;
    chk(n == 216, "R9", "latency with ignored starts", n, 216);
    gates_are("R9", 5, 0, 0);
    pulses = 0;
    repeat (300) begin
      @(posedge clk); #1;
      if (done) pulses++;
    end
    chk(pulses == 0, "R9", "extra done pulses", pulses, 0);
    gates_are("R9", 5, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule